// File: doc/BRIEF.md
# Stuck-At Fault Detection Harness for a Two-Input XOR

This block wraps a single two-input XOR gate with the logic needed to show how single stuck-at faults are revealed. A model of the gate can be given one fault at a time: either input or the output held at 0 or at 1. A golden copy of the gate runs beside it with no fault. A short sequencer applies a fixed set of three input vectors, one per clock. On each vector it compares the golden output with the faulty one and records the result in a per-vector mismatch mask.

To use it, place a fault code on the select input and pulse start. Three cycles of vectors follow. Then a one-cycle done pulse marks the point where the mask is complete. The detected output is high when at least one vector revealed the fault. The three vectors together reveal every one of the six single stuck-at faults. With no fault injected, nothing is detected.

Top module: `xor_fault_harness`

## Requirements
- R1: While reset is held, and in the cycle after it is released, busy, done, miss_mask and detected are all 0.
- R2: The fault code sampled with an accepted start selects the injected fault: 0 = none, 1 = A stuck at 0, 2 = A stuck at 1, 3 = B stuck at 0, 4 = B stuck at 1, 5 = F stuck at 0, 6 = F stuck at 1, 7 = none.
- R3: After an accepted start, busy is high for exactly three cycles. During those cycles (vec_a, vec_b) reads 00, then 01, then 11.
- R4: Bit i of miss_mask is set exactly when the fault-free XOR output and the faulty output differ on vector i. Bit 0 belongs to vector 00, bit 1 to vector 01 and bit 2 to vector 11.
- R5: Done is high for exactly one cycle, the cycle right after the third vector. From that cycle on, miss_mask holds the complete result until the next accepted start.
- R6: Detected is the OR of the miss_mask bits. It reads 0 for codes 0 and 7, and 1 at done for each of codes 1 to 6.
- R7: A start pulse while busy is high has no effect on the vectors, the mask or the cycle in which done arrives. No second run follows the first one.
- R8: Changing the fault code while busy is high has no effect on the result of the run in progress.
- R9: An accepted start clears miss_mask to 0 before the first vector's result is stored.
- R10: Asserting reset in the middle of a run aborts it: busy, done and miss_mask read 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; accepted only when not busy |
| fault_sel | input | 3 | Fault code, sampled with an accepted start |
| vec_a | output | 1 | Vector bit driven onto gate input A |
| vec_b | output | 1 | Vector bit driven onto gate input B |
| busy | output | 1 | High while vectors are being applied |
| done | output | 1 | One-cycle pulse when the mask is complete |
| miss_mask | output | 3 | Per-vector mismatch record |
| detected | output | 1 | High when any vector revealed the fault |

## Verification
The checker tests these rules on every cycle:
- done lasts a single cycle and never overlaps busy;
- busy only falls into done;
- the vectors step 00 to 01 to 11 in consecutive busy cycles;
- the mask starts each run cleared;
- a run latched with the no-fault code ends with an empty mask.

Only the bench's scenarios can show the values of the per-fault masks, the coverage of all six faults, and that start pulses or changes to the fault code during a run are ignored. The same holds for the effect of a reset in the middle of a run.

// File: rtl/xfh_pkg.sv
package xfh_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    FLT_NONE = 3'd0,
    FLT_A0   = 3'd1,
    FLT_A1   = 3'd2,
    FLT_B0   = 3'd3,
    FLT_B1   = 3'd4,
    FLT_F0   = 3'd5,
    FLT_F1   = 3'd6,
    FLT_RSV  = 3'd7
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/xfh_gate.sv
module xfh_gate
  import xfh_pkg::*;
(
  input  logic   in_a,
  input  logic   in_b,
  input  fault_e fault,
  output logic   f_good,
  output logic   f_bad
);
  logic a_eff;
  logic b_eff;
  logic f_raw;

  always_comb begin
    a_eff = in_a;
    b_eff = in_b;
    case (fault)
      FLT_A0:  a_eff = 1'b0;
      FLT_A1:  a_eff = 1'b1;
      FLT_B0:  b_eff = 1'b0;
      FLT_B1:  b_eff = 1'b1;
      default: ;
    endcase
  end

  assign f_raw  = a_eff ^ b_eff;
  assign f_good = in_a ^ in_b;

  always_comb begin
    case (fault)
      FLT_F0:  f_bad = 1'b0;
      FLT_F1:  f_bad = 1'b1;
      default: f_bad = f_raw;
    endcase
  end
endmodule

// File: rtl/xfh_vecsrc.sv
module xfh_vecsrc #(
  parameter int NUM_VEC = 3,
  parameter int IDX_W   = 2
) (
  input  logic [IDX_W-1:0] idx,
  output logic             vec_a,
  output logic             vec_b
);
  logic [1:0] table_q [NUM_VEC];

  // Successive vectors differ in one bit: entry i is i xor (i >> 1).
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_entry
    localparam logic [1:0] ENT = 2'(g ^ (g >> 1));
    assign table_q[g] = ENT;
  end

  always_comb begin
    vec_a = 1'b0;
    vec_b = 1'b0;
    for (int k = 0; k < NUM_VEC; k++) begin
      if (idx == IDX_W'(k)) begin
        vec_a = table_q[k][1];
        vec_b = table_q[k][0];
      end
    end
  end
endmodule

// File: rtl/xfh_seq.sv
module xfh_seq
  import xfh_pkg::*;
#(
  parameter int NUM_VEC = 3,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SEL_W-1:0]   fault_sel,
  input  logic               mismatch,
  output logic [IDX_W-1:0]   idx,
  output fault_e             sel_q,
  output logic [NUM_VEC-1:0] mask,
  output logic               busy,
  output logic               done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_VEC - 1);

  seq_st_e            st_q, st_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [NUM_VEC-1:0] mask_q, mask_d;
  fault_e             sel_d;
  logic               en;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    mask_d = mask_q;
    sel_d  = sel_q;
    case (st_q)
      ST_RUN: begin
        mask_d[idx_q] = mismatch;
        if (idx_q == LAST) st_d = ST_FIN;
        else               idx_d = idx_q + 1'b1;
      end
      default: begin
        if (start) begin
          st_d   = ST_RUN;
          idx_d  = '0;
          mask_d = '0;
          sel_d  = fault_e'(fault_sel);
        end else if (st_q == ST_FIN) begin
          st_d = ST_IDLE;
        end
      end
    endcase
    en = (st_q != ST_IDLE) || start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      mask_q <= '0;
      sel_q  <= FLT_NONE;
    end else if (en) begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      mask_q <= mask_d;
      sel_q  <= sel_d;
    end
  end

  assign idx  = idx_q;
  assign mask = mask_q;
  assign busy = (st_q == ST_RUN);
  assign done = (st_q == ST_FIN);
endmodule

// File: rtl/xor_fault_harness.sv
module xor_fault_harness
  import xfh_pkg::*;
#(
  parameter int NUM_VEC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SEL_W-1:0]   fault_sel,
  output logic               vec_a,
  output logic               vec_b,
  output logic               busy,
  output logic               done,
  output logic [NUM_VEC-1:0] miss_mask,
  output logic               detected
);
  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [IDX_W-1:0] idx;
  fault_e           sel_q;
  logic             f_good;
  logic             f_bad;
  logic             mismatch;

  xfh_seq #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .fault_sel(fault_sel),
    .mismatch(mismatch), .idx(idx), .sel_q(sel_q), .mask(miss_mask),
    .busy(busy), .done(done)
  );

  xfh_vecsrc #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) i_vec (
    .idx(idx), .vec_a(vec_a), .vec_b(vec_b)
  );

  xfh_gate i_gate (
    .in_a(vec_a), .in_b(vec_b), .fault(sel_q),
    .f_good(f_good), .f_bad(f_bad)
  );

  assign mismatch = f_good ^ f_bad;
  assign detected = |miss_mask;
endmodule

// File: rtl/xfh_chk.sv
module xfh_chk
  import xfh_pkg::*;
#(
  parameter int NUM_VEC = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               vec_a,
  input logic               vec_b,
  input logic [NUM_VEC-1:0] mask,
  input fault_e             sel_q
);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !vec_a && !vec_b) |=> (busy && !vec_a && vec_b));

  // R3
  step_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !vec_a && vec_b) |=> (busy && vec_a && vec_b));

  // R3
  step_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && vec_a && vec_b) |=> done);

  // R9
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mask == '0));

  // R6
  none_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (sel_q == FLT_NONE || sel_q == FLT_RSV)) |-> (mask == '0));
endmodule

bind xor_fault_harness xfh_chk #(.NUM_VEC(NUM_VEC)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .vec_a(vec_a), .vec_b(vec_b), .mask(miss_mask), .sel_q(sel_q)
);

// File: tb/test_xor_fault_harness.sv
`timescale 1ns/1ps
module test_xor_fault_harness;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] fault_sel = 3'd0;
  logic       vec_a, vec_b, busy, done, detected;
  logic [2:0] miss_mask;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xor_fault_harness i_xor_fault_harness (
    .clk(clk), .rst_n(rst_n), .start(start), .fault_sel(fault_sel),
    .vec_a(vec_a), .vec_b(vec_b), .busy(busy), .done(done),
    .miss_mask(miss_mask), .detected(detected)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected mask from the requirement text: vectors 00, 01, 11 in bit order 0..2.
  function automatic logic [2:0] exp_mask(input int code);
    logic [2:0] m;
    for (int i = 0; i < 3; i++) begin
      logic a, b, aa, bb, good, fb;
      a = (i == 2);
      b = (i != 0);
      good = a ^ b;
      aa = (code == 1) ? 1'b0 : (code == 2) ? 1'b1 : a;
      bb = (code == 3) ? 1'b0 : (code == 4) ? 1'b1 : b;
      fb = aa ^ bb;
      if (code == 5) fb = 1'b0;
      if (code == 6) fb = 1'b1;
      m[i] = good ^ fb;
    end
    return m;
  endfunction

  // mode 0: plain; 1: extra start pulses during run; 2: code change during run
  task automatic run(input int code, input int mode);
    logic [2:0] em;
    em = exp_mask(code);
    @(negedge clk);
    fault_sel = 3'(code);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int v = 0; v < 3; v++) begin
      chk(busy === 1'b1 && done === 1'b0, "R3 busy", busy, 1);
      chk({vec_a, vec_b} === 2'(v ^ (v >> 1)), "R3 vector", {vec_a, vec_b}, v ^ (v >> 1));
      if (v == 0) chk(miss_mask === 3'd0, "R9 cleared", miss_mask, 0);
      if (mode == 1) start = 1'b1;
      if (mode == 2) fault_sel = 3'(6 - code);
      @(negedge clk);
      start = 1'b0;
    end
    chk(done === 1'b1 && busy === 1'b0, "R5 done", done, 1);
    chk(miss_mask === em, (mode == 1) ? "R7 mask" : (mode == 2) ? "R8 mask" : "R4 mask",
        miss_mask, em);
    chk(detected === (|em), "R6 detected", detected, |em);
    if (code >= 1 && code <= 6) chk(detected === 1'b1, "R2 fault caught", detected, 1);
    else chk(detected === 1'b0, "R2 no fault", detected, 0);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, (mode == 1) ? "R7 no rerun" : "R5 single done",
        {busy, done}, 0);
    chk(miss_mask === em, "R5 hold", miss_mask, em);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #7;
    chk(busy === 1'b0 && done === 1'b0 && miss_mask === 3'd0 && detected === 1'b0,
        "R1 in reset", {busy, done, miss_mask}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && miss_mask === 3'd0 && detected === 1'b0,
        "R1 after reset", {busy, done, miss_mask}, 0);
    for (int c = 0; c < 8; c++) run(c, 0);
    for (int c = 0; c < 8; c++) run(c, 1);
    for (int c = 0; c < 8; c++) run(c, 2);
    run(4, 0);
    run(0, 0);
    // R10: reset during a run
    @(negedge clk);
    fault_sel = 3'd5;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(busy === 1'b0 && done === 1'b0 && miss_mask === 3'd0, "R10 abort",
        {busy, done, miss_mask}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R10 idle after", {busy, done}, 0);
    run(5, 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule